// File: doc/BRIEF.md
# Host-Bus Slave Byte Port

This block lets an external host processor exchange single bytes with a small controller core through an 8-bit parallel port. The host drives three active-low control lines: a chip select, a read strobe and a write strobe. None of them is related to the core clock. Each line passes through a two-flop synchroniser. A three-state machine then follows the host transaction. It completes a write on the trailing (rising) edge of the write strobe, and it follows a read for as long as the read strobe stays low.

Both sides share one 8-bit holding latch. A completed host write loads the latch from the port pins. The pin data is registered once in the core clock domain before it is loaded. The same write pulls the active-low host notification line low. The core loads the latch and reads it in two 4-bit halves. When the core reads the upper half, the notification line returns high. During a host read, the latch byte is driven onto the port only if the core has set its driver-enable bit. When the read strobe rises again, the port returns to high impedance.

The state machine has three states:
- ST_IDLE, the bus is free.
- ST_WRITE, a selected write strobe is low.
- ST_READ, a selected read strobe is low.

It has four transitions:
- "write start" goes from ST_IDLE to ST_WRITE when the synchronised chip select and write strobe are both low. A write wins over a read if both strobes are low.
- "read start" goes from ST_IDLE to ST_READ when the synchronised chip select and read strobe are low and the write strobe is high.
- "write end" goes from ST_WRITE to ST_IDLE when the synchronised write strobe is high. This is the capture cycle.
- "read end" goes from ST_READ to ST_IDLE when the synchronised read strobe is high.

Top module: `hostbus_port`

## Requirements
- R1: After reset, the latch is 0x00, host_irq_n is 1, port_oe is 0, the driver enable is 0, and the state machine is in ST_IDLE.
- R2: A host write with host_cs_n low loads the latch with the byte on port_in. The load happens in the cycle in which the synchronised write strobe is first seen high after ST_WRITE was entered.
- R3: host_irq_n goes low exactly three clock edges after host_wr_n rises. It is still unchanged after the second edge.
- R4: A one-cycle core_rd_en pulse with core_rd_sel=1 (upper half) sets host_irq_n high. The same pulse with core_rd_sel=0 (lower half) leaves it unchanged. If such a pulse falls in the capture cycle, host_irq_n goes low.
- R5: During ST_READ with the driver enable set, port_oe is 1 and port_out equals the latch. port_oe is 0 again three edges after host_rd_n rises. port_oe is never 1 in a capture cycle.
- R6: When the driver enable is 0, a host read leaves port_oe at 0. core_drv_wr loads the enable from core_drv_val.
- R7: Strobes seen while host_cs_n is high change neither the latch nor host_irq_n, and they leave port_oe at 0.
- R8: core_wr_lo loads core_wdata into latch bits 3:0, and core_wr_hi loads it into bits 7:4. core_rdata shows bits 3:0 when core_rd_sel=0 and bits 7:4 when core_rd_sel=1.
- R9: A core nibble write in the capture cycle is lost, and the latch holds the host byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| port_in | input | 8 | Byte seen at the port pins |
| port_out | output | 8 | Byte driven to the port pins (zero when not enabled) |
| port_oe | output | 1 | Port pin driver enable; 0 means high impedance |
| host_irq_n | output | 1 | Active-low write notification to the host |
| core_wr_lo | input | 1 | Core write of latch bits 3:0 |
| core_wr_hi | input | 1 | Core write of latch bits 7:4 |
| core_wdata | input | 4 | Nibble written by the core |
| core_rd_sel | input | 1 | Nibble selected for core_rdata (1 = upper) |
| core_rd_en | input | 1 | Core read pulse; with core_rd_sel=1 it releases host_irq_n |
| core_rdata | output | 4 | Selected latch nibble |
| core_drv_wr | input | 1 | Load the driver enable from core_drv_val |
| core_drv_val | input | 1 | Driver enable value |

## Verification
Two pairs of core actions can land in the same clock edge as the host write capture.
- A core nibble write can coincide with the capture. The bench raises core_wr_lo and core_wr_hi just before the third edge after the write strobe rises. It then expects the latch to hold the host byte and none of the core nibble.
- A core upper-half read can coincide with the capture. The bench places a core_rd_en pulse with core_rd_sel=1 on that same edge. It then expects host_irq_n to be low after the edge.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } hbp_state_t;
endpackage

// File: rtl/hbp_sync.sv
// Multi-stage synchroniser for active-low asynchronous lines; resets to inactive (1).
module hbp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hbp_fsm.sv
// Host transaction tracker: idle, write-in-progress, read-in-progress.
module hbp_fsm
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_n,
    input  logic rd_s_n,
    input  logic wr_s_n,
    output logic capture,
    output logic read_act
);
    hbp_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_s_n && !wr_s_n)      state_nx = ST_WRITE;  // write start
                else if (!cs_s_n && !rd_s_n) state_nx = ST_READ;   // read start
            end
            ST_WRITE: if (wr_s_n) state_nx = ST_IDLE;               // write end
            ST_READ:  if (rd_s_n) state_nx = ST_IDLE;               // read end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture  = 1'b0;
        read_act = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: capture  = wr_s_n;
            ST_READ:  read_act = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hbp_qreg.sv
// Shared byte latch, host notification flag and driver-enable bit.
module hbp_qreg #(
    parameter int DATA_W = 8,
    localparam int NIB_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] pin_byte,
    input  logic              core_wr_lo,
    input  logic              core_wr_hi,
    input  logic [NIB_W-1:0]  core_wdata,
    input  logic              core_rd_hi,
    input  logic              core_drv_wr,
    input  logic              core_drv_val,
    output logic [DATA_W-1:0] q,
    output logic              irq_n,
    output logic              drv_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (capture) begin
            q <= pin_byte;
        end else begin
            if (core_wr_lo) q[NIB_W-1:0]      <= core_wdata;
            if (core_wr_hi) q[DATA_W-1:NIB_W] <= core_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq_n <= 1'b1;
        else if (capture)    irq_n <= 1'b0;
        else if (core_rd_hi) irq_n <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           drv_en <= 1'b0;
        else if (core_drv_wr) drv_en <= core_drv_val;
    end
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NIB_W      = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic              host_irq_n,
    input  logic              core_wr_lo,
    input  logic              core_wr_hi,
    input  logic [NIB_W-1:0]  core_wdata,
    input  logic              core_rd_sel,
    input  logic              core_rd_en,
    output logic [NIB_W-1:0]  core_rdata,
    input  logic              core_drv_wr,
    input  logic              core_drv_val
);
    logic [2:0]        strb_s;
    logic [DATA_W-1:0] pin_q;
    logic [DATA_W-1:0] q_reg;
    logic              capture;
    logic              read_act;
    logic              drv_en;

    hbp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({host_cs_n, host_rd_n, host_wr_n}),
        .q_sync  (strb_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= port_in;
    end

    hbp_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s_n   (strb_s[2]),
        .rd_s_n   (strb_s[1]),
        .wr_s_n   (strb_s[0]),
        .capture  (capture),
        .read_act (read_act)
    );

    hbp_qreg #(.DATA_W(DATA_W)) qreg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .pin_byte     (pin_q),
        .core_wr_lo   (core_wr_lo),
        .core_wr_hi   (core_wr_hi),
        .core_wdata   (core_wdata),
        .core_rd_hi   (core_rd_en && core_rd_sel),
        .core_drv_wr  (core_drv_wr),
        .core_drv_val (core_drv_val),
        .q            (q_reg),
        .irq_n        (host_irq_n),
        .drv_en       (drv_en)
    );

    assign port_oe    = read_act && drv_en;
    assign port_out   = port_oe ? q_reg : '0;
    assign core_rdata = core_rd_sel ? q_reg[DATA_W-1:NIB_W] : q_reg[NIB_W-1:0];
endmodule

// File: rtl/hbp_chk.sv
module hbp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_oe,
    input logic [DATA_W-1:0] q,
    input logic [DATA_W-1:0] pin_q,
    input logic              cap,
    input logic              irq_n,
    input logic              drv_en,
    input logic              core_wr_lo,
    input logic              core_wr_hi,
    input logic              core_rd_en,
    input logic              core_rd_sel
);
    // R2 R9
    cap_loads_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> q == $past(pin_q));

    // R3
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(cap));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> ($past(core_rd_en && core_rd_sel) && !$past(cap)));

    // R5
    oe_not_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_oe |-> !cap);

    // R6
    oe_needs_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_oe |-> drv_en);

    // R7 R8
    q_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(cap || core_wr_lo || core_wr_hi));
endmodule

bind hostbus_port hbp_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_oe     (port_oe),
    .q           (q_reg),
    .pin_q       (pin_q),
    .cap         (capture),
    .irq_n       (host_irq_n),
    .drv_en      (drv_en),
    .core_wr_lo  (core_wr_lo),
    .core_wr_hi  (core_wr_hi),
    .core_rd_en  (core_rd_en),
    .core_rd_sel (core_rd_sel)
);

// File: tb/hostbus_port_tb_top.sv
`timescale 1ns/100ps
module hostbus_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] port_in = '0;
    logic [7:0] port_out;
    logic       port_oe, host_irq_n;
    logic       core_wr_lo = 0, core_wr_hi = 0, core_rd_sel = 0, core_rd_en = 0;
    logic [3:0] core_wdata = '0;
    logic [3:0] core_rdata;
    logic       core_drv_wr = 0, core_drv_val = 0;
    int         n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    hostbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
        .host_irq_n(host_irq_n), .core_wr_lo(core_wr_lo), .core_wr_hi(core_wr_hi),
        .core_wdata(core_wdata), .core_rd_sel(core_rd_sel), .core_rd_en(core_rd_en),
        .core_rdata(core_rdata), .core_drv_wr(core_drv_wr), .core_drv_val(core_drv_val)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_q(output logic [7:0] v);
        core_rd_sel = 1'b0; #0.4; v[3:0] = core_rdata;
        core_rd_sel = 1'b1; #0.4; v[7:4] = core_rdata;
    endtask

    task automatic set_drv(input logic val);
        @(negedge clk); core_drv_wr = 1'b1; core_drv_val = val;
        @(negedge clk); core_drv_wr = 1'b0;
    endtask

    // mode 0: plain, 1: core nibble writes on capture edge, 2: core upper read on capture edge
    task automatic host_write(input logic [7:0] d, input int mode, input logic irq_before);
        @(negedge clk); host_cs_n = 1'b0; port_in = d;
        repeat (2) @(negedge clk); host_wr_n = 1'b0;
        repeat (4) @(negedge clk); host_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 irq before third edge", {7'd0, host_irq_n}, {7'd0, irq_before});
        if (mode == 1) begin core_wr_lo = 1; core_wr_hi = 1; core_wdata = 4'h7; end
        if (mode == 2) begin core_rd_en = 1; core_rd_sel = 1; end
        @(negedge clk);
        core_wr_lo = 0; core_wr_hi = 0; core_rd_en = 0;
        check("R3 irq low after third edge", {7'd0, host_irq_n}, 8'd0);
        repeat (2) @(negedge clk); host_cs_n = 1'b1; port_in = 8'h00;
    endtask

    task automatic host_read(input string req, input logic exp_oe, input logic [7:0] exp_d);
        @(negedge clk); host_cs_n = 1'b0;
        repeat (2) @(negedge clk); host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check({req, " oe during read"}, {7'd0, port_oe}, {7'd0, exp_oe});
        if (exp_oe) check({req, " data during read"}, port_out, exp_d);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 oe released after read", {7'd0, port_oe}, 8'd0);
        host_cs_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        repeat (3) @(negedge clk);
        read_q(v);
        check("R1 latch", v, 8'h00);
        check("R1 irq", {7'd0, host_irq_n}, 8'd1);
        check("R1 oe", {7'd0, port_oe}, 8'd0);
        rst_n = 1'b1;
        host_read("R1 drv off", 1'b0, 8'h00);
    endtask

    task automatic t_core_nibbles();
        logic [7:0] v;
        @(negedge clk); core_wr_lo = 1; core_wdata = 4'h5;
        @(negedge clk); core_wr_lo = 0; core_wr_hi = 1; core_wdata = 4'hA;
        @(negedge clk); core_wr_hi = 0;
        read_q(v);
        check("R8 nibble writes", v, 8'hA5);
        check("R8 rdata upper", {4'd0, core_rdata}, 8'h0A);
    endtask

    task automatic t_host_write();
        logic [7:0] v;
        host_write(8'h3C, 0, 1'b1);
        read_q(v);
        check("R2 captured byte", v, 8'h3C);
    endtask

    task automatic t_irq_release();
        @(negedge clk); core_rd_en = 1; core_rd_sel = 0;
        @(negedge clk); core_rd_en = 0;
        check("R4 lower read keeps irq", {7'd0, host_irq_n}, 8'd0);
        core_rd_en = 1; core_rd_sel = 1;
        @(negedge clk); core_rd_en = 0;
        check("R4 upper read releases irq", {7'd0, host_irq_n}, 8'd1);
    endtask

    task automatic t_read_enabled();
        set_drv(1'b1);
        host_read("R5", 1'b1, 8'h3C);
    endtask

    task automatic t_read_disabled();
        set_drv(1'b0);
        host_read("R6", 1'b0, 8'h00);
        set_drv(1'b1);
    endtask

    task automatic t_no_cs();
        logic [7:0] v;
        @(negedge clk); port_in = 8'hFF; host_wr_n = 1'b0;
        repeat (4) @(negedge clk); host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        read_q(v);
        check("R7 latch unchanged", v, 8'h3C);
        check("R7 irq unchanged", {7'd0, host_irq_n}, 8'd1);
        host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 oe stays off", {7'd0, port_oe}, 8'd0);
        host_rd_n = 1'b1; port_in = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        host_write(8'h81, 1, 1'b1);
        read_q(v);
        check("R9 host wins over core write", v, 8'h81);
    endtask

    task automatic t_irq_race();
        logic [7:0] v;
        @(negedge clk); core_rd_en = 1; core_rd_sel = 1;
        @(negedge clk); core_rd_en = 0;
        check("R4 release before race", {7'd0, host_irq_n}, 8'd1);
        host_write(8'h6E, 2, 1'b1);
        check("R4 capture wins over release", {7'd0, host_irq_n}, 8'd0);
        read_q(v);
        check("R2 second byte", v, 8'h6E);
    endtask

    initial begin
        t_reset();
        t_core_nibbles();
        t_host_write();
        t_irq_release();
        t_read_enabled();
        t_read_disabled();
        t_no_cs();
        t_collision();
        t_irq_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule